// File: doc/BRIEF.md
# Effective Address Generator with Indirection

This block forms the target address of a memory-reference instruction on a machine with 16-bit words and a 15-bit address space. The decoder hands it an 8-bit displacement, a 2-bit mode, an indirect flag and a class bit. The class bit says whether the instruction transfers control or moves data. The decoder also supplies the program counter and two accumulators. The block adds the displacement to one of four bases, and the sum wraps modulo 2^15.

When the indirect flag is set, the block reads the word at the computed address through a synchronous read port and uses that word as the new address. Data-class instructions always stop after one pointer. Jump-class instructions follow another pointer whenever bit 15 of the fetched word is 1. A depth parameter caps this chain. If the cap is reached and the last pointer still asks to continue, the block ends the chain, raises an error flag and still completes. A pointer that refers to itself therefore cannot stall the pipeline.

Top module: `ea_gen`

## Requirements
- R1: Mode 0 gives an address equal to the zero-extended displacement, so bits 14..8 are 0.
- R2: Mode 1 gives the program counter plus the sign-extended displacement, modulo 2^15.
- R3: Mode 2 gives bits 14..0 of accumulator 2 plus the sign-extended displacement, modulo 2^15.
- R4: Mode 3 gives bits 14..0 of accumulator 3 plus the sign-extended displacement, modulo 2^15. Bit 15 of the accumulator has no effect.
- R5: Without the indirect flag, `done_o` is high for exactly one cycle, in the cycle after the start edge. `mem_req_o` stays low.
- R6: Each indirection raises `mem_req_o` for one cycle with the address on `mem_addr_o`. The block samples `mem_rdata_i` one cycle later, and bits 14..0 of that word become the new address. A run with n reads completes 2n+1 cycles after the start edge.
- R7: Data class (`jump_i`=0) with the indirect flag performs exactly one read, whatever bit 15 of the fetched word is.
- R8: Jump class (`jump_i`=1) performs another read whenever bit 15 of the fetched word is 1, and stops on the first word whose bit 15 is 0.
- R9: If read number MAX_IND (default 8) returns a word with bit 15 set, the block stops. It then raises `err_o` together with `done_o`, with `addr_o` set to bits 14..0 of that word. A chain whose MAX_IND-th word has bit 15 clear completes without error. `err_o` stays until the next accepted start.
- R10: `start_i` is ignored while `busy_o` is high. The running result is unchanged, and no extra completion follows.
- R11: Right after reset, `done_o`, `err_o`, `mem_req_o` and `busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a computation; sampled only when idle |
| disp_i | input | 8 | Instruction displacement field |
| mode_i | input | 2 | Addressing mode: 0 page zero, 1 PC-relative, 2 AC2-indexed, 3 AC3-indexed |
| ind_i | input | 1 | Indirect flag |
| jump_i | input | 1 | 1 for control-transfer class, 0 for data class |
| pc_i | input | 15 | Address of the next instruction |
| ac2_i | input | 16 | Accumulator 2 |
| ac3_i | input | 16 | Accumulator 3 |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 15 | Read address |
| mem_rdata_i | input | 16 | Read data, valid the cycle after the request |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| addr_o | output | 15 | Effective address, valid with done_o |
| err_o | output | 1 | Indirection depth exceeded |

## Verification
Two events can land on the same cycle: the read that uses up the depth budget and a fetched word whose continue bit is still set. In that cycle the block must raise the error and complete at once. A self-referencing jump pointer provokes this case. The bench judges it on the error flag, the masked address and a latency of 2*MAX_IND+1. A second chain ends exactly on the MAX_IND-th word and must finish cleanly. Start pulses issued during busy cycles test that a pending request is not merged into a running one.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  typedef enum logic [1:0] {
    MODE_ABS = 2'd0,
    MODE_PC  = 2'd1,
    MODE_AC2 = 2'd2,
    MODE_AC3 = 2'd3
  } ea_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } ea_state_e;
endpackage

// File: rtl/ea_base.sv
module ea_base
  import ea_gen_pkg::*;
#(
  parameter int AW     = 15,
  parameter int DW     = 16,
  parameter int DISP_W = 8
) (
  input  logic [DISP_W-1:0] disp_i,
  input  logic [1:0]        mode_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [DW-1:0]     ac2_i,
  input  logic [DW-1:0]     ac3_i,
  output logic [AW-1:0]     base_o
);
  localparam int PAD = AW - DISP_W;

  logic [AW-1:0] zext, sext, idx;
  ea_mode_e mode;

  assign mode = ea_mode_e'(mode_i);
  assign zext = {{PAD{1'b0}}, disp_i};
  assign sext = {{PAD{disp_i[DISP_W-1]}}, disp_i};

  always_comb begin
    unique case (mode)
      MODE_PC:  idx = pc_i;
      MODE_AC2: idx = ac2_i[AW-1:0];
      MODE_AC3: idx = ac3_i[AW-1:0];
      default:  idx = '0;
    endcase
  end

  // modulo 2^AW by truncation
  assign base_o = (mode == MODE_ABS) ? zext : idx + sext;
endmodule

// File: rtl/ea_walk.sv
module ea_walk
  import ea_gen_pkg::*;
#(
  parameter int AW      = 15,
  parameter int DW      = 16,
  parameter int MAX_IND = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ind_i,
  input  logic          jump_i,
  input  logic [AW-1:0] base_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] addr_o,
  output logic          err_o
);
  localparam int CNT_W = $clog2(MAX_IND + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(MAX_IND);

  ea_state_e      state_q;
  logic [AW-1:0]  ptr_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic           jump_q, err_q, more;

  assign cnt_nxt = cnt_q + 1'b1;
  assign more    = jump_q & mem_rdata_i[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      cnt_q   <= '0;
      jump_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ptr_q   <= base_i;
          cnt_q   <= '0;
          jump_q  <= jump_i;
          err_q   <= 1'b0;
          state_q <= ind_i ? ST_REQ : ST_DONE;
        end
        ST_REQ: state_q <= ST_WAIT;
        ST_WAIT: begin
          ptr_q <= mem_rdata_i[AW-1:0];
          cnt_q <= cnt_nxt;
          if (more && cnt_nxt == CNT_LIM) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else if (more) begin
            state_q <= ST_REQ;
          end else begin
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_REQ);
  assign mem_addr_o = ptr_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign addr_o     = ptr_q;
  assign err_o      = err_q;

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DIRECT_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !ind_i) |=> (done_o && !mem_req_o)); // R5
  AST_ERR_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o); // R9
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LIM); // R9
  AST_DATA_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !jump_q) |-> (cnt_q == '0)); // R7
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int AW      = 15,
  parameter int DW      = 16,
  parameter int DISP_W  = 8,
  parameter int MAX_IND = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [1:0]        mode_i,
  input  logic              ind_i,
  input  logic              jump_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [DW-1:0]     ac2_i,
  input  logic [DW-1:0]     ac3_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [AW-1:0]     addr_o,
  output logic              err_o
);
  logic [AW-1:0] base;

  ea_base #(.AW(AW), .DW(DW), .DISP_W(DISP_W)) u_base (
    .disp_i (disp_i),
    .mode_i (mode_i),
    .pc_i   (pc_i),
    .ac2_i  (ac2_i),
    .ac3_i  (ac3_i),
    .base_o (base)
  );

  ea_walk #(.AW(AW), .DW(DW), .MAX_IND(MAX_IND)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .ind_i       (ind_i),
    .jump_i      (jump_i),
    .base_i      (base),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .addr_o      (addr_o),
    .err_o       (err_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !done_o)); // R11
endmodule

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
  localparam int MAX_IND = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  disp = '0;
  logic [1:0]  mode = '0;
  logic        ind = 1'b0, jump = 1'b0;
  logic [14:0] pc = '0;
  logic [15:0] ac2 = '0, ac3 = '0;
  logic        mem_req, busy, done, err;
  logic [14:0] mem_addr, addr;
  logic [15:0] mem_rdata = '0;
  logic [15:0] tbl [256];

  int n_chk = 0, n_fail = 0;
  bit wd_hit = 1'b0;

  always #4 clk = ~clk;

  ea_gen #(.MAX_IND(MAX_IND)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .disp_i(disp), .mode_i(mode),
    .ind_i(ind), .jump_i(jump), .pc_i(pc), .ac2_i(ac2), .ac3_i(ac3),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .addr_o(addr), .err_o(err)
  );

  always @(posedge clk) if (mem_req) mem_rdata <= tbl[mem_addr[7:0]];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] base_of(logic [7:0] d, logic [1:0] m, logic [14:0] p,
                                          logic [15:0] a2, logic [15:0] a3);
    logic [14:0] s = {{7{d[7]}}, d};
    case (m)
      2'd0: return {7'd0, d};
      2'd1: return p + s;
      2'd2: return a2[14:0] + s;
      default: return a3[14:0] + s;
    endcase
  endfunction

  task automatic run(string req, logic [7:0] d, logic [1:0] m, logic i, logic j,
                     logic [14:0] p, logic [15:0] a2, logic [15:0] a3, bit poke);
    logic [14:0] ea;
    logic [15:0] w;
    int reads = 0, lat = 1, guard = 0;
    bit e = 1'b0;
    ea = base_of(d, m, p, a2, a3);
    if (i) begin
      do begin
        w = tbl[ea[7:0]];
        reads++;
        ea = w[14:0];
        if (j && w[15] && reads == MAX_IND) begin e = 1'b1; break; end
      end while (j && w[15]);
    end
    @(negedge clk);
    disp = d; mode = m; ind = i; jump = j; pc = p; ac2 = a2; ac3 = a3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 100) begin
      if (poke) begin
        start = 1'b1; disp = ~d; mode = ~m; ind = ~i; jump = ~j; pc = ~p;
      end
      @(negedge clk);
      start = 1'b0;
      lat++; guard++;
    end
    check({req, " done"}, done, 1'b1);
    check({req, " addr"}, addr, ea);
    check({req, " err"}, err, e);
    check({req, " latency"}, lat, i ? 2 * reads + 1 : 1);
    @(negedge clk);
    check({req, " done pulse"}, done, 1'b0);
    // R10: no second completion from a poked start
    if (poke) begin
      @(negedge clk);
      check("R10 no extra op", {busy, done}, 2'b00);
    end
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    wd_hit = 1'b1;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 256; k++) tbl[k] = 16'($urandom);
    tbl[8'h40] = 16'h8040;                         // self reference
    for (int k = 1; k < MAX_IND; k++) tbl[8'h50 + k - 1] = 16'h8000 | 16'(8'h50 + k);
    tbl[8'h50 + MAX_IND - 1] = 16'h1234;           // ends on last permitted read
    tbl[8'h60] = 16'hC123;

    repeat (3) @(negedge clk);
    check("R11 done", done, 1'b0);
    check("R11 err", err, 1'b0);
    check("R11 req", mem_req, 1'b0);
    check("R11 busy", busy, 1'b0);
    rst_n = 1'b1;

    run("R1 page zero", 8'hFF, 2'd0, 0, 0, 15'h1234, 16'h0, 16'h0, 0);
    run("R2 pc neg", 8'h80, 2'd1, 0, 0, 15'h0010, 16'h0, 16'h0, 0);
    run("R2 pc wrap", 8'h05, 2'd1, 0, 0, 15'h7FFE, 16'h0, 16'h0, 0);
    run("R3 ac2", 8'hFF, 2'd2, 0, 0, 15'h0, 16'h8000, 16'h0, 0);
    run("R4 ac3 bit15", 8'h01, 2'd3, 0, 1, 15'h0, 16'h0, 16'hFFFF, 0);
    run("R5 direct", 8'h22, 2'd0, 0, 1, 15'h0, 16'h0, 16'h0, 0);
    run("R6 single", 8'h60, 2'd0, 1, 0, 15'h0, 16'h0, 16'h0, 0);
    run("R7 data stops", 8'h40, 2'd0, 1, 0, 15'h0, 16'h0, 16'h0, 0);
    run("R8 jump chain", 8'h50, 2'd0, 1, 1, 15'h0, 16'h0, 16'h0, 0);
    run("R9 self loop", 8'h40, 2'd0, 1, 1, 15'h0, 16'h0, 16'h0, 0);
    run("R9 err cleared", 8'h10, 2'd0, 0, 0, 15'h0, 16'h0, 16'h0, 0);
    run("R10 poke", 8'h50, 2'd0, 1, 1, 15'h0, 16'h0, 16'h0, 1);
    run("R10 poke direct", 8'h33, 2'd2, 0, 0, 15'h0, 16'h0100, 16'h0, 1);

    for (int n = 0; n < 300; n++) begin
      logic [1:0] m = 2'($urandom);
      run(m == 0 ? "R1 rnd" : m == 1 ? "R2 rnd" : m == 2 ? "R3 rnd" : "R4 rnd",
          8'($urandom), m, 1'($urandom), 1'($urandom), 15'($urandom),
          16'($urandom), 16'($urandom), ($urandom % 8) == 0);
    end

    if (!wd_hit) begin
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule